// File: doc/BRIEF.md
# Function-Unit Dependency Matrix

This block tracks ordering between in-flight instructions held in a set of function units. It is a square matrix with one row and one column per unit, and each cell holds two wait bits. Row i, column j holds whether unit i must wait for unit j. The write-wait bit means unit j has not yet produced a result that unit i reads. The read-wait bit means unit j has not yet read an operand that unit i will overwrite. The set bits form a directed acyclic graph between in-flight operations. Each unit's position in the matrix is its identity, so no tag is stored and no comparison of tags takes place.

When an instruction is issued to a unit, the issue logic sends two dependency vectors: the units it must wait on for writes, and the units it must wait on for reads. The unit's row is overwritten with these vectors. When unit j finishes reading its operands, it pulses its go-read line. When it writes its result, it pulses its go-write line. Each pulse clears the matching bits in column j of every row. A unit is readable when its row holds no write-wait bit, and writable when its row holds no read-wait bit. Each flag is a wide NOR across the row. Precise exceptions are not handled.

Top module: `fu_dep_matrix`

## Requirements
- R1: While reset is asserted, and after it is released, every wait bit is clear, so every `readable` and `writable` bit reads 1.
- R2: When `issueFu[i]` is 1 at a clock edge, row i is loaded from the dependency vectors. After that edge, `readable[i]` is 0 exactly when `issueWrDep` has a bit set other than bit i and that bit has no `goWrite` pulse in the same cycle. `writable[i]` follows the same rule using `issueRdDep` and `goRead`.
- R3: Issuing to a unit discards the previous contents of its row. Bits set by an earlier issue that are absent from the new vectors stay clear.
- R4: A 1 on `goWrite[j]` at a clock edge clears column j's write-wait bit in every row. A row with no other write-wait bit becomes readable after that edge.
- R5: A 1 on `goRead[j]` at a clock edge clears column j's read-wait bit in every row. A row with no other read-wait bit becomes writable after that edge.
- R6: The diagonal cell is never set. Bit i of either vector, when issuing to unit i, has no effect on `readable[i]` or `writable[i]`.
- R7: The two bit planes are independent. `goRead` has no effect on any `readable` output, and `goWrite` has no effect on any `writable` output.
- R8: A go pulse on column j in the same cycle as an issue also clears bit j of the row being loaded.
- R9: In a cycle with no issue and no go pulse, all outputs hold their values.
- R10: When several bits of `issueFu` are set in one cycle, every selected row is loaded from the same vectors. Each row masks its own diagonal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| issueFu | input | NUM_FU | Rows to load this cycle, one bit per unit |
| issueWrDep | input | NUM_FU | Units whose result the issuing unit waits for |
| issueRdDep | input | NUM_FU | Units whose operand read the issuing unit waits for |
| goRead | input | NUM_FU | Per-unit pulse: the unit has read its operands |
| goWrite | input | NUM_FU | Per-unit pulse: the unit has written its result |
| readable | output | NUM_FU | Per unit: no write-wait bit is pending in its row |
| writable | output | NUM_FU | Per unit: no read-wait bit is pending in its row |

## Verification
Every state change takes effect at one clock edge. The flags are combinational NORs of the stored bits, so an issue or go pulse presented before edge k shows on `readable`/`writable` after edge k, one cycle later, and not before. The bench drives inputs on the falling edge. It advances its reference model on the rising edge using the inputs that were presented, and compares both flag vectors at the next falling edge. Directed sequences come first: reset, load, overwrite, column clears, the diagonal, collisions of an issue with a go pulse, and multi-row issue. A long run of random stimulus follows, checked the same way on every cycle.

// File: rtl/fu_dep_pkg.sv
package fu_dep_pkg;
  // Per-unit strobes from control to the matrix storage.
  typedef struct packed {
    logic loadRow;   // overwrite this unit's row
    logic clrRdCol;  // clear this unit's column, read-wait plane
    logic clrWrCol;  // clear this unit's column, write-wait plane
  } fuStrobe_t;
endpackage

// File: rtl/fu_dep_ctrl.sv
module fu_dep_ctrl
  import fu_dep_pkg::*;
#(
  parameter int NUM_FU = 8
) (
  input  logic [NUM_FU-1:0] issueFu,
  input  logic [NUM_FU-1:0] issueWrDep,
  input  logic [NUM_FU-1:0] issueRdDep,
  input  logic [NUM_FU-1:0] goRead,
  input  logic [NUM_FU-1:0] goWrite,
  output fuStrobe_t         strobes [NUM_FU],
  output logic [NUM_FU-1:0] wrDepLoad,
  output logic [NUM_FU-1:0] rdDepLoad
);
  // A dependency on a unit that completes in this same cycle is already met.
  always_comb begin
    wrDepLoad = issueWrDep & ~goWrite;
    rdDepLoad = issueRdDep & ~goRead;
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_strobe
    always_comb begin
      strobes[u].loadRow  = issueFu[u];
      strobes[u].clrRdCol = goRead[u];
      strobes[u].clrWrCol = goWrite[u];
    end
  end
endmodule

// File: rtl/fu_dep_array.sv
module fu_dep_array
  import fu_dep_pkg::*;
#(
  parameter int NUM_FU = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fuStrobe_t         strobes [NUM_FU],
  input  logic [NUM_FU-1:0] wrDepLoad,
  input  logic [NUM_FU-1:0] rdDepLoad,
  output logic [NUM_FU-1:0] readable,
  output logic [NUM_FU-1:0] writable
);
  logic [NUM_FU-1:0] clrWrVec;
  logic [NUM_FU-1:0] clrRdVec;
  logic [NUM_FU-1:0] waitWr [NUM_FU];
  logic [NUM_FU-1:0] waitRd [NUM_FU];

  for (genvar c = 0; c < NUM_FU; c++) begin : g_col
    assign clrWrVec[c] = strobes[c].clrWrCol;
    assign clrRdVec[c] = strobes[c].clrRdCol;
  end

  for (genvar r = 0; r < NUM_FU; r++) begin : g_row
    localparam logic [NUM_FU-1:0] OffDiag = ~(NUM_FU'(1) << r);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        waitWr[r] <= '0;
        waitRd[r] <= '0;
      end else if (strobes[r].loadRow) begin
        waitWr[r] <= wrDepLoad & OffDiag;
        waitRd[r] <= rdDepLoad & OffDiag;
      end else begin
        waitWr[r] <= waitWr[r] & ~clrWrVec;
        waitRd[r] <= waitRd[r] & ~clrRdVec;
      end
    end

    assign readable[r] = ~|waitWr[r];
    assign writable[r] = ~|waitRd[r];
  end
endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix
  import fu_dep_pkg::*;
#(
  parameter int NUM_FU = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_FU-1:0] issueFu,
  input  logic [NUM_FU-1:0] issueWrDep,
  input  logic [NUM_FU-1:0] issueRdDep,
  input  logic [NUM_FU-1:0] goRead,
  input  logic [NUM_FU-1:0] goWrite,
  output logic [NUM_FU-1:0] readable,
  output logic [NUM_FU-1:0] writable
);
  fuStrobe_t         strobes [NUM_FU];
  logic [NUM_FU-1:0] wrDepLoad;
  logic [NUM_FU-1:0] rdDepLoad;

  fu_dep_ctrl #(.NUM_FU(NUM_FU)) i_ctrl (
    .issueFu(issueFu), .issueWrDep(issueWrDep), .issueRdDep(issueRdDep),
    .goRead(goRead), .goWrite(goWrite),
    .strobes(strobes), .wrDepLoad(wrDepLoad), .rdDepLoad(rdDepLoad)
  );

  fu_dep_array #(.NUM_FU(NUM_FU)) i_array (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrDepLoad(wrDepLoad), .rdDepLoad(rdDepLoad),
    .readable(readable), .writable(writable)
  );
endmodule

// File: rtl/fu_dep_chk.sv
module fu_dep_chk #(
  parameter int NUM_FU = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_FU-1:0] issueFu,
  input logic [NUM_FU-1:0] issueWrDep,
  input logic [NUM_FU-1:0] issueRdDep,
  input logic [NUM_FU-1:0] goRead,
  input logic [NUM_FU-1:0] goWrite,
  input logic [NUM_FU-1:0] readable,
  input logic [NUM_FU-1:0] writable
);
  // R4: all write-wait columns cleared, nothing loaded -> every unit readable
  a_r4_all_readable: assert property (@(posedge clk) disable iff (!rstN)
    (issueFu == '0 && &goWrite) |=> &readable);

  // R5: all read-wait columns cleared, nothing loaded -> every unit writable
  a_r5_all_writable: assert property (@(posedge clk) disable iff (!rstN)
    (issueFu == '0 && &goRead) |=> &writable);

  // R9: idle cycle holds the flags
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (issueFu == '0 && goRead == '0 && goWrite == '0)
    |=> ($stable(readable) && $stable(writable)));

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    localparam logic [NUM_FU-1:0] OffDiag = ~(NUM_FU'(1) << u);

    // R2: a pending off-diagonal write dependency blocks reading
    a_r2_load_blocks_read: assert property (@(posedge clk) disable iff (!rstN)
      (issueFu[u] && |(issueWrDep & ~goWrite & OffDiag)) |=> !readable[u]);

    // R2: a pending off-diagonal read dependency blocks writing
    a_r2_load_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
      (issueFu[u] && |(issueRdDep & ~goRead & OffDiag)) |=> !writable[u]);

    // R6: dependencies on itself alone leave the unit free
    a_r6_diag_ignored: assert property (@(posedge clk) disable iff (!rstN)
      (issueFu[u] && (issueWrDep & OffDiag) == '0 && (issueRdDep & OffDiag) == '0)
      |=> (readable[u] && writable[u]));
  end
endmodule

bind fu_dep_matrix fu_dep_chk #(.NUM_FU(NUM_FU)) i_chk (
  .clk(clk), .rstN(rstN), .issueFu(issueFu), .issueWrDep(issueWrDep),
  .issueRdDep(issueRdDep), .goRead(goRead), .goWrite(goWrite),
  .readable(readable), .writable(writable)
);

// File: tb/test_fu_dep_matrix.sv
module test_fu_dep_matrix;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] issueFu = '0;
  logic [N-1:0] issueWrDep = '0;
  logic [N-1:0] issueRdDep = '0;
  logic [N-1:0] goRead = '0;
  logic [N-1:0] goWrite = '0;
  logic [N-1:0] readable;
  logic [N-1:0] writable;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // Reference state: per unit, the set of units it still waits on.
  logic [N-1:0] mWr [N];
  logic [N-1:0] mRd [N];

  always #10 clk = ~clk;  // 50 MHz

  fu_dep_matrix #(.NUM_FU(N)) i_fu_dep_matrix (
    .clk(clk), .rstN(rstN), .issueFu(issueFu), .issueWrDep(issueWrDep),
    .issueRdDep(issueRdDep), .goRead(goRead), .goWrite(goWrite),
    .readable(readable), .writable(writable)
  );

  task automatic modelClear();
    for (int i = 0; i < N; i++) begin
      mWr[i] = '0;
      mRd[i] = '0;
    end
  endtask

  task automatic modelAdvance();
    for (int i = 0; i < N; i++) begin
      if (!rstN) begin
        mWr[i] = '0;
        mRd[i] = '0;
      end else if (issueFu[i]) begin
        mWr[i] = '0;
        mRd[i] = '0;
        for (int j = 0; j < N; j++) begin
          if (j != i && issueWrDep[j] && !goWrite[j]) mWr[i][j] = 1'b1;
          if (j != i && issueRdDep[j] && !goRead[j])  mRd[i][j] = 1'b1;
        end
      end else begin
        for (int j = 0; j < N; j++) begin
          if (goWrite[j]) mWr[i][j] = 1'b0;
          if (goRead[j])  mRd[i][j] = 1'b0;
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [N-1:0] expR;
    logic [N-1:0] expW;
    for (int i = 0; i < N; i++) begin
      expR[i] = (mWr[i] == '0);
      expW[i] = (mRd[i] == '0);
    end
    checks++;
    if (readable !== expR || writable !== expW) begin
      bad++;
      $display("FAIL %s: readable=%b writable=%b expected readable=%b writable=%b",
               tag, readable, writable, expR, expW);
    end
  endtask

  // Present inputs, clock once, compare at the following falling edge.
  task automatic step(input logic [N-1:0] fu, input logic [N-1:0] wd,
                      input logic [N-1:0] rd, input logic [N-1:0] gr,
                      input logic [N-1:0] gw, input string tag);
    issueFu = fu; issueWrDep = wd; issueRdDep = rd; goRead = gr; goWrite = gw;
    @(posedge clk);
    modelAdvance();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step('0, '0, '0, '0, '0, tag);
  endtask

  initial begin
    modelClear();
    @(negedge clk);
    // R1: flags during and after reset
    step(8'hFF, 8'hFF, 8'hFF, '0, '0, "R1 reset ignores issue");
    step('0, '0, '0, '0, '0, "R1 reset");
    rstN = 1'b1;
    idle("R1 after reset");

    // R2: load rows
    step(8'h01, 8'h06, 8'h00, '0, '0, "R2 load write deps u0");
    step(8'h08, 8'h00, 8'h21, '0, '0, "R2 load read deps u3");
    idle("R9 idle hold");
    idle("R9 idle hold again");

    // R7: planes independent
    step('0, '0, '0, 8'hFF, '0, "R7 goRead leaves readable");
    step(8'h08, 8'h00, 8'h21, '0, '0, "R2 reload u3");
    step('0, '0, '0, '0, 8'hFF, "R7 goWrite leaves writable");

    // R4 / R5 single-column clears
    step(8'h01, 8'h06, 8'h00, '0, '0, "R2 reload u0");
    step('0, '0, '0, '0, 8'h02, "R4 clear column 1 only");
    step('0, '0, '0, '0, 8'h04, "R4 clear column 2 frees u0");
    step('0, '0, '0, 8'h01, '0, "R5 clear column 0");
    step('0, '0, '0, 8'h20, '0, "R5 clear column 5 frees u3");

    // R3: overwrite
    step(8'h10, 8'hC0, 8'h03, '0, '0, "R3 first load u4");
    step(8'h10, 8'h00, 8'h00, '0, '0, "R3 overwrite u4 empty");
    step(8'h10, 8'h01, 8'h00, '0, '0, "R3 overwrite u4");

    // R6: diagonal
    step(8'h04, 8'h04, 8'h04, '0, '0, "R6 self dependency ignored");
    step(8'h80, 8'h80, 8'h81, '0, '0, "R6 diagonal with other bit");

    // R8: collision of issue with go pulse
    step(8'h02, 8'h0C, 8'h30, 8'h10, 8'h04, "R8 go pulse masks load");
    step(8'h40, 8'h01, 8'h01, 8'h01, 8'h01, "R8 full mask");

    // R10: multi-row issue
    step(8'h21, 8'h03, 8'h22, '0, '0, "R10 two rows share vectors");
    step('0, '0, '0, 8'hFF, 8'hFF, "R4 R5 clear all");

    // Random run
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] f;
      f = (k % 3 == 0) ? N'(1) << ($urandom % N) : '0;
      if (k % 17 == 0) f = N'($urandom);
      step(f, N'($urandom), N'($urandom),
           N'($urandom) & N'($urandom), N'($urandom) & N'($urandom),
           "R2 R4 R5 R8 random");
      if (k == 300) begin
        rstN = 1'b0;
        step('0, '0, '0, '0, '0, "R1 mid reset");
        rstN = 1'b1;
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule